// File: doc/BRIEF.md
# Byte-Serial Peripheral Port with Latched Status

This block is a byte-wide SPI engine that sits on a small CPU register bus. It can run as bus master or as slave. In master mode, writing the data register loads the byte straight into the shifter and starts an 8-bit exchange. The block then drives the serial clock from the system clock through a programmable half-period divider. In slave mode, the engine follows an external clock and only responds while its select input is held low.

Three events are caught as sticky flags in a read-only status byte:
- a finished byte,
- a write to the data register during a transfer,
- another device pulling select low while this one is master.

Any read of the status byte clears all three flags. The interrupt line is the finish flag gated by its enable. Transmit and receive share one register address: a write feeds the shifter, and a read returns the last byte received.

Top module: `spi_port`

## Requirements
- R1: The status register (address 2) shows the done flag at bit 7, the collision flag at bit 6 and the mode-fault flag at bit 4. All other bits read 0, and all flags are 0 after reset.
- R2: Any bus read of the status register clears all three flags. If a flag sets in the same cycle as the read, the set takes priority.
- R3: When the block is enabled as master, a write to the data register (address 3) starts an 8-bit transfer, shifting MSB first on the MOSI pin. When the block is disabled, the write does not start a transfer and causes no SCK activity.
- R4: The master SCK toggles once every H system clocks, where H is the divisor register (address 1, reset value 1), and a value of 0 acts as 1. SCK rests at the CPOL level when idle.
- R5: With CPHA=0, the first bit is presented before the first clock edge, data is sampled on the leading edges and changed on the trailing edges. With CPHA=1, data is changed on the leading edges and sampled on the trailing edges.
- R6: In both master and slave mode, the done flag sets, and the receive buffer takes the received byte, on the same clock edge that ends the 16th SCK edge of a byte.
- R7: The interrupt output equals the done flag ANDed with the interrupt-enable bit, so it falls when a status read clears the flag.
- R8: A data-register write while a transfer is active sets the collision flag. The written byte is ignored and the transfer in progress continues unchanged.
- R9: If the synchronized select input is low while the block is enabled as master, the block sets the mode-fault flag and clears the master bit. The block then stops driving SCK and MOSI (both output enables low).
- R10: A read of the data register returns the last received byte, which is 0 after reset.
- R11: In slave mode, the block shifts only while select is low, using the synchronized external SCK and MOSI pins. It drives MISO (enable high) only while it is enabled, is a slave and is selected.
- R12: The control register (address 0) reads back with enable at bit 0, master at bit 1, CPOL at bit 2, CPHA at bit 3 and interrupt enable at bit 4. Bits 7..5 read 0, and the register is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Bus select |
| wr_i | input | 1 | Bus write strobe |
| rd_i | input | 1 | Bus read strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Bus write data |
| rdata_o | output | 8 | Bus read data |
| irq_o | output | 1 | Transfer-complete interrupt |
| sck_i | input | 1 | Serial clock in (slave) |
| sck_o | output | 1 | Serial clock out (master) |
| sck_oe_o | output | 1 | SCK output enable |
| mosi_i | input | 1 | Serial data in (slave) |
| mosi_o | output | 1 | Serial data out (master) |
| mosi_oe_o | output | 1 | MOSI output enable |
| miso_i | input | 1 | Serial data in (master) |
| miso_o | output | 1 | Serial data out (slave) |
| miso_oe_o | output | 1 | MISO output enable |
| ss_ni | input | 1 | Select, active low |

## Verification
A miscounted edge counter shows up one byte-time later as a late or missing done flag, a shifted receive byte, and an extra or missing SCK toggle at the pin. A divider or phase register that is off shows up within one bit period as a wrong SCK spacing or a mis-sampled bit. A flag that does not clear is visible at the next status read and on the interrupt line. A mode-fault path that does not fire leaves the SCK and MOSI enables high a few cycles after select falls.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;
  localparam int BUS_W = 8;
  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_DIV  = 2'd1;
  localparam logic [1:0] A_STAT = 2'd2;
  localparam logic [1:0] A_DATA = 2'd3;
  localparam int BIT_DONE = 7;
  localparam int BIT_WCOL = 6;
  localparam int BIT_MODF = 4;

  typedef struct packed {
    logic [2:0] rsvd;
    logic       irq_en;
    logic       cpha;
    logic       cpol;
    logic       master;
    logic       enable;
  } ctrl_t;
endpackage

// File: rtl/spi_clk_div.sv
module spi_clk_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] half_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] lim;

  assign lim    = (half_i == '0) ? DIV_W'(1) : half_i;
  assign tick_o = run_i && (cnt_q == lim - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (!run_i || tick_o) cnt_q <= '0;
    else                       cnt_q <= cnt_q + 1'b1;
  end

  assert_tick_spacing_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && lim != DIV_W'(1) && $stable(half_i)) |=> !tick_o);
endmodule

// File: rtl/spi_shift.sv
module spi_shift #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [DW-1:0] load_i,
  input  logic          abort_i,
  input  logic          master_i,
  input  logic          cpol_i,
  input  logic          cpha_i,
  input  logic          tick_i,
  input  logic          sck_edge_i,
  input  logic          sck_lvl_i,
  input  logic          in_bit_i,
  output logic          run_o,
  output logic          done_o,
  output logic [DW-1:0] rx_o,
  output logic          out_bit_o,
  output logic          sck_ph_o
);
  localparam int EDGES = 2 * DW;
  localparam int CW    = $clog2(EDGES);
  localparam logic [CW-1:0] LAST = CW'(EDGES - 1);

  logic          run_q, ph_q, out_q;
  logic [CW-1:0] cnt_q;
  logic [DW-1:0] sr_q, sr_shift;
  logic          edge_ev, lead, trail, sample_ev, drive_ev;

  assign edge_ev   = master_i ? (tick_i && run_q) : sck_edge_i;
  assign lead      = edge_ev && (master_i ? !ph_q : (sck_lvl_i != cpol_i));
  assign trail     = edge_ev && !lead;
  assign sample_ev = !abort_i && (cpha_i ? trail : lead);
  assign drive_ev  = !abort_i && (cpha_i ? lead : trail);
  assign sr_shift  = {sr_q[DW-2:0], in_bit_i};
  assign done_o    = trail && (cnt_q == LAST);
  assign rx_o      = sample_ev ? sr_shift : sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      ph_q  <= 1'b0;
      cnt_q <= '0;
    end else if (abort_i) begin
      run_q <= 1'b0;
      ph_q  <= 1'b0;
      cnt_q <= '0;
    end else if (start_i) begin
      run_q <= master_i;
      ph_q  <= 1'b0;
      cnt_q <= '0;
    end else if (edge_ev) begin
      cnt_q <= done_o ? '0 : cnt_q + 1'b1;
      if (master_i) ph_q <= !ph_q;
      if (done_o)   run_q <= 1'b0;
    end
  end

  // one register serves both directions: rx enters at LSB as tx leaves at MSB
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q  <= '0;
      out_q <= 1'b0;
    end else if (start_i) begin
      sr_q  <= load_i;
      out_q <= load_i[DW-1];
    end else begin
      if (sample_ev) sr_q  <= sr_shift;
      if (drive_ev)  out_q <= sr_q[DW-1];
    end
  end

  assign run_o     = run_q;
  assign out_bit_o = out_q;
  assign sck_ph_o  = ph_q;

  assert_sr_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && !sample_ev) |=> $stable(sr_q));
  assert_done_stops_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && master_i && !start_i) |=> (!run_q && !ph_q));
endmodule

// File: rtl/spi_flags.sv
module spi_flags (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic set_done_i,
  input  logic set_wcol_i,
  input  logic set_modf_i,
  input  logic irq_en_i,
  output logic done_o,
  output logic wcol_o,
  output logic modf_o,
  output logic irq_o
);
  localparam int NF = 3;
  logic [NF-1:0] set_v, flag_q;

  assign set_v = {set_modf_i, set_wcol_i, set_done_i};

  for (genvar i = 0; i < NF; i++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       flag_q[i] <= 1'b0;
      else if (set_v[i]) flag_q[i] <= 1'b1;
      else if (clr_i)    flag_q[i] <= 1'b0;
    end

    assert_clear_on_read_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i && !set_v[i]) |=> !flag_q[i]);
    assert_set_wins_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_v[i] |=> flag_q[i]);
  end

  assign done_o = flag_q[0];
  assign wcol_o = flag_q[1];
  assign modf_o = flag_q[2];
  assign irq_o  = flag_q[0] && irq_en_i;
endmodule

// File: rtl/spi_port.sv
module spi_port
  import spi_port_pkg::*;
#(
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sel_i,
  input  logic             wr_i,
  input  logic             rd_i,
  input  logic [1:0]       addr_i,
  input  logic [BUS_W-1:0] wdata_i,
  output logic [BUS_W-1:0] rdata_o,
  output logic             irq_o,
  input  logic             sck_i,
  output logic             sck_o,
  output logic             sck_oe_o,
  input  logic             mosi_i,
  output logic             mosi_o,
  output logic             mosi_oe_o,
  input  logic             miso_i,
  output logic             miso_o,
  output logic             miso_oe_o,
  input  logic             ss_ni
);
  logic [SYNC_STAGES-1:0] sck_sy, ss_sy, mosi_sy;
  logic                   sck_q;
  ctrl_t                  ctrl_q;
  logic [BUS_W-1:0]       div_q;
  logic [DW-1:0]          rx_q, rx_next;
  logic                   sck_s, ss_act, mosi_s;
  logic                   wr_ctrl, wr_div, wr_data, rd_stat;
  logic                   busy, data_wr_ok, start, wcol_set, mode_fault, abort;
  logic                   tick, run, done, out_bit, sck_ph, sck_edge;
  logic                   f_done, f_wcol, f_modf;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_sy  <= '0;
      ss_sy   <= '1;
      mosi_sy <= '0;
      sck_q   <= 1'b0;
    end else begin
      sck_sy  <= {sck_sy[SYNC_STAGES-2:0], sck_i};
      ss_sy   <= {ss_sy[SYNC_STAGES-2:0], ss_ni};
      mosi_sy <= {mosi_sy[SYNC_STAGES-2:0], mosi_i};
      sck_q   <= sck_s;
    end
  end

  assign sck_s  = sck_sy[SYNC_STAGES-1];
  assign ss_act = !ss_sy[SYNC_STAGES-1];
  assign mosi_s = mosi_sy[SYNC_STAGES-1];

  assign wr_ctrl = sel_i && wr_i && (addr_i == A_CTRL);
  assign wr_div  = sel_i && wr_i && (addr_i == A_DIV);
  assign wr_data = sel_i && wr_i && (addr_i == A_DATA);
  assign rd_stat = sel_i && rd_i && (addr_i == A_STAT);

  assign busy       = ctrl_q.master ? run : ss_act;
  assign data_wr_ok = wr_data && ctrl_q.enable;
  assign start      = data_wr_ok && !busy;
  assign wcol_set   = data_wr_ok && busy;
  assign mode_fault = ctrl_q.enable && ctrl_q.master && ss_act;
  assign abort      = !ctrl_q.enable || mode_fault || (!ctrl_q.master && !ss_act);
  assign sck_edge   = ss_act && (sck_s != sck_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      div_q  <= BUS_W'(1);
      rx_q   <= '0;
    end else begin
      if (wr_ctrl)    ctrl_q <= ctrl_t'({3'b000, wdata_i[4:0]});
      if (mode_fault) ctrl_q.master <= 1'b0;
      if (wr_div)     div_q <= wdata_i;
      if (done)       rx_q <= rx_next;
    end
  end

  spi_clk_div #(.DIV_W(BUS_W)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .half_i (div_q),
    .tick_o (tick)
  );

  spi_shift #(.DW(DW)) u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .load_i     (DW'(wdata_i)),
    .abort_i    (abort),
    .master_i   (ctrl_q.master),
    .cpol_i     (ctrl_q.cpol),
    .cpha_i     (ctrl_q.cpha),
    .tick_i     (tick),
    .sck_edge_i (sck_edge),
    .sck_lvl_i  (sck_s),
    .in_bit_i   (ctrl_q.master ? miso_i : mosi_s),
    .run_o      (run),
    .done_o     (done),
    .rx_o       (rx_next),
    .out_bit_o  (out_bit),
    .sck_ph_o   (sck_ph)
  );

  spi_flags u_flags (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (rd_stat),
    .set_done_i (done),
    .set_wcol_i (wcol_set),
    .set_modf_i (mode_fault),
    .irq_en_i   (ctrl_q.irq_en),
    .done_o     (f_done),
    .wcol_o     (f_wcol),
    .modf_o     (f_modf),
    .irq_o      (irq_o)
  );

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_CTRL: rdata_o = ctrl_q;
      A_DIV:  rdata_o = div_q;
      A_STAT: begin
        rdata_o[BIT_DONE] = f_done;
        rdata_o[BIT_WCOL] = f_wcol;
        rdata_o[BIT_MODF] = f_modf;
      end
      default: rdata_o = BUS_W'(rx_q);
    endcase
  end

  assign sck_o     = ctrl_q.cpol ^ sck_ph;
  assign sck_oe_o  = ctrl_q.enable && ctrl_q.master;
  assign mosi_o    = out_bit;
  assign mosi_oe_o = ctrl_q.enable && ctrl_q.master;
  assign miso_o    = out_bit;
  assign miso_oe_o = ctrl_q.enable && !ctrl_q.master && ss_act;

  assert_done_flag_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |=> f_done);
  assert_rx_capture_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |=> (rx_q == $past(rx_next)));
  assert_irq_raise_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done && ctrl_q.irq_en && !wr_ctrl) |=> irq_o);
  assert_wcol_flag_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wcol_set |=> f_wcol);
  assert_modf_fallback_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_fault |=> (f_modf && !ctrl_q.master && !sck_oe_o && !mosi_oe_o));
endmodule

// File: tb/spi_port_test.sv
module spi_port_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sel = 0, wr = 0, rd = 0;
  logic [1:0] addr = 0;
  logic [7:0] wdata = 0, rdata;
  logic       irq, sck_o, sck_oe, mosi_o, mosi_oe, miso_o, miso_oe;
  logic       sck_i = 0, mosi_i = 0, miso_i = 0, ss_n = 1;
  int         checks = 0, failures = 0;

  always #4 clk = ~clk;

  spi_port uut (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .wr_i(wr), .rd_i(rd),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq),
    .sck_i(sck_i), .sck_o(sck_o), .sck_oe_o(sck_oe),
    .mosi_i(mosi_i), .mosi_o(mosi_o), .mosi_oe_o(mosi_oe),
    .miso_i(miso_i), .miso_o(miso_o), .miso_oe_o(miso_oe), .ss_ni(ss_n)
  );

  // {cpol, cpha, half, tx, slave reply, irq enable}
  localparam logic [26:0] VECS [6] = '{
    {1'b0, 1'b0, 8'd1, 8'hA5, 8'h3C, 1'b1},
    {1'b0, 1'b1, 8'd2, 8'h5A, 8'hC3, 1'b0},
    {1'b1, 1'b0, 8'd3, 8'hFF, 8'h00, 1'b1},
    {1'b1, 1'b1, 8'd1, 8'h01, 8'h80, 1'b0},
    {1'b0, 1'b0, 8'd0, 8'h80, 8'h01, 1'b1},
    {1'b1, 1'b1, 8'd4, 8'h6E, 8'hB9, 1'b1}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); sel = 1; wr = 1; addr = a; wdata = d;
    @(negedge clk); sel = 0; wr = 0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); sel = 1; rd = 1; addr = a;
    #1 d = rdata;
    @(negedge clk); sel = 0; rd = 0;
  endtask

  task automatic master_xfer(input logic cpol, input logic cpha, input logic [7:0] h,
                             input logic [7:0] tx, input logic [7:0] pat, input logic ie,
                             input bit collide, input logic [7:0] exp_stat);
    logic [7:0] cap, r;
    int edges, cyc, last, guard, heff;
    bit per_ok;
    heff = (h == 0) ? 1 : h;
    ss_n = 1;
    bus_wr(2'd0, {3'b0, ie, cpha, cpol, 2'b11});
    bus_wr(2'd1, h);
    chk(sck_o == cpol, "R4 idle level before", sck_o, cpol);
    miso_i = cpha ? 1'b0 : pat[7];
    bus_wr(2'd3, tx);
    edges = 0; cyc = 0; last = 0; guard = 0; per_ok = 1; cap = 0;
    while (edges < 16 && guard < 5000) begin
      @(negedge clk); cyc++; guard++;
      if (sck_o !== (cpol ^ edges[0])) begin
        int j;
        if (edges > 0 && (cyc - last) != heff) per_ok = 0;
        last = cyc;
        j = edges / 2;
        if (!edges[0]) begin
          if (!cpha) cap[7-j] = mosi_o; else miso_i = pat[7-j];
        end else begin
          if (cpha) cap[7-j] = mosi_o; else if (j < 7) miso_i = pat[6-j];
        end
        edges++;
        if (collide && edges == 6) begin
          @(negedge clk); sel = 1; wr = 1; addr = 2'd3; wdata = 8'h11;
          @(negedge clk); sel = 0; wr = 0;
          cyc += 2;
        end
      end
    end
    chk(edges == 16, "R3 edge count", edges, 16);
    chk(irq == ie, "R7 irq at completion", irq, ie);
    chk(per_ok, "R4 SCK half period", per_ok, 1);
    chk(cap == tx, "R3 R5 R8 MOSI bits", cap, tx);
    repeat (heff + 2) @(negedge clk);
    chk(sck_o == cpol, "R4 idle level after", sck_o, cpol);
    bus_rd(2'd3, r);
    chk(r == pat, "R5 R10 received byte", r, pat);
    bus_rd(2'd2, r);
    chk(r == exp_stat, "R1 status after transfer", r, exp_stat);
    chk(irq == 1'b0, "R7 irq drops after status read", irq, 0);
    bus_rd(2'd2, r);
    chk(r == 8'h00, "R2 status cleared", r, 0);
  endtask

  task automatic slave_xfer(input logic cpol, input logic cpha, input logic [7:0] tx, input logic [7:0] pat);
    logic [7:0] cap, r;
    ss_n = 1; sck_i = cpol; miso_i = 0;
    bus_wr(2'd0, {3'b0, 1'b1, cpha, cpol, 2'b01});
    repeat (4) @(negedge clk);
    bus_wr(2'd3, tx);
    ss_n = 0;
    repeat (6) @(negedge clk);
    chk(miso_oe == 1'b1, "R11 MISO driven when selected", miso_oe, 1);
    cap = 0;
    for (int b = 7; b >= 0; b--) begin
      if (!cpha) begin
        mosi_i = pat[b];
        repeat (6) @(negedge clk);
        cap[b] = miso_o;
        sck_i = ~cpol;
        repeat (6) @(negedge clk);
        sck_i = cpol;
      end else begin
        sck_i = ~cpol;
        mosi_i = pat[b];
        repeat (6) @(negedge clk);
        cap[b] = miso_o;
        sck_i = cpol;
        repeat (6) @(negedge clk);
      end
    end
    repeat (6) @(negedge clk);
    chk(irq == 1'b1, "R6 R7 slave completion irq", irq, 1);
    chk(cap == tx, "R11 slave MISO bits", cap, tx);
    bus_rd(2'd3, r);
    chk(r == pat, "R6 R11 slave received byte", r, pat);
    bus_rd(2'd2, r);
    chk(r == 8'h80, "R1 slave status", r, 8'h80);
    ss_n = 1;
    repeat (4) @(negedge clk);
    chk(miso_oe == 1'b0, "R11 MISO released when deselected", miso_oe, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog R3 actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // reset state
    bus_rd(2'd2, r); chk(r == 8'h00, "R1 status after reset", r, 0);
    bus_rd(2'd0, r); chk(r == 8'h00, "R12 control after reset", r, 0);
    bus_rd(2'd1, r); chk(r == 8'h01, "R4 divisor after reset", r, 1);
    bus_rd(2'd3, r); chk(r == 8'h00, "R10 receive buffer after reset", r, 0);
    chk({irq, sck_oe, mosi_oe, miso_oe} == 4'b0, "R7 R11 outputs idle after reset",
        {irq, sck_oe, mosi_oe, miso_oe}, 0);

    // register map readback, reserved bits dropped
    bus_wr(2'd0, 8'hFE);
    bus_rd(2'd0, r); chk(r == 8'h1E, "R12 control readback", r, 8'h1E);

    // vector table
    for (int i = 0; i < 6; i++) begin
      master_xfer(VECS[i][26], VECS[i][25], VECS[i][24:17], VECS[i][16:9],
                  VECS[i][8:1], VECS[i][0], 1'b0, 8'h80);
    end

    // write collision mid-transfer
    master_xfer(1'b0, 1'b0, 8'd4, 8'hC3, 8'h5D, 1'b0, 1'b1, 8'hC0);

    // disabled: data write starts nothing
    bus_wr(2'd0, 8'h02);
    bus_wr(2'd3, 8'h55);
    begin
      bit moved = 0;
      for (int k = 0; k < 40; k++) begin
        @(negedge clk);
        if (sck_o !== 1'b0) moved = 1;
      end
      chk(!moved, "R3 no SCK when disabled", moved, 0);
    end
    bus_rd(2'd2, r); chk(r == 8'h00, "R3 no completion when disabled", r, 0);
    bus_rd(2'd3, r); chk(r == 8'h5D, "R10 buffer kept", r, 8'h5D);

    // mode fault
    bus_wr(2'd0, 8'h03);
    chk(sck_oe && mosi_oe, "R9 master drives before fault", {sck_oe, mosi_oe}, 2'b11);
    ss_n = 0;
    repeat (5) @(negedge clk);
    chk(!sck_oe && !mosi_oe, "R9 drivers released", {sck_oe, mosi_oe}, 0);
    bus_rd(2'd0, r); chk(r == 8'h01, "R9 master bit cleared", r, 8'h01);
    ss_n = 1;
    repeat (4) @(negedge clk);
    bus_rd(2'd2, r); chk(r == 8'h10, "R9 R1 mode-fault flag", r, 8'h10);
    bus_rd(2'd2, r); chk(r == 8'h00, "R2 mode-fault cleared", r, 0);

    // slave transfers
    slave_xfer(1'b0, 1'b0, 8'h96, 8'h3B);
    slave_xfer(1'b1, 1'b1, 8'h4D, 8'hE2);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule